// File: doc/BRIEF.md
# Byte-wide execute unit with shifter

This unit is the data path of a small 8-bit accumulator controller. Each instruction is a 16-bit word. The unit takes that word and the two operand bytes that an external eight-entry register file reads for it. It returns the byte to write back, a write strobe and the destination index. The ZERO and CARRY flags are held inside the unit and are shown on outputs.

The unit covers four kinds of instruction:
- loads;
- the three bitwise operations;
- add and subtract, each with and without the incoming carry;
- shifts and rotates.

It also has one instruction that reverses the bit order of a byte. Every instruction takes exactly two clock cycles. The caller holds the instruction word and the operands stable for both cycles. The unit counts the two phases itself, starting from the first edge after reset is released. On the second edge it commits the result and the flags. For the cycle that follows, `wr_en_o` is high and `result_o` and `wr_addr_o` carry the write-back.

Top module: `alu8_exec`

## Requirements
- R1: An instruction occupies two cycles counted from reset release. After the second edge, `wr_en_o` is high for exactly one cycle, `wr_addr_o` equals instruction bits 10:8 (sX), and flags do not change in the following cycle.
- R2: When bits 15:15 are 0, bit 14 selects the second operand: 0 takes the constant in bits 7:0, and 1 takes `y_val_i`, which is the register named by bits 7:5.
- R3: LOAD (bits 13:11 = 000, bit 15 = 0) writes the second operand to sX and leaves both flags unchanged. For example, 0x0701 writes 0x01 to s7.
- R4: AND (001), OR (010) and XOR (011) write the bitwise result and clear CARRY.
- R5: ADD (100) writes x+b and sets CARRY to the carry out of bit 7. ADDCY (101) also adds the current CARRY.
- R6: SUB (110) writes x-b and sets CARRY to the borrow. SUBCY (111) also subtracts the current CARRY.
- R7: Every instruction that updates the flags sets ZERO exactly when the written byte is 0x00.
- R8: Opcode 10100 with bit 3 = 0 shifts left and moves bit 7 into CARRY. The fill code in bits 2:0 selects the bit that enters bit 0: 110 gives 0, 111 gives 1, 010 gives bit 0, 000 gives CARRY, and 100 gives bit 7 (rotate). For example, 0xA706 shifts s7 left and fills with 0.
- R9: Opcode 10100 with bit 3 = 1 shifts right and moves bit 0 into CARRY. The fill code selects the bit that enters bit 7: 110 gives 0, 111 gives 1, 010 gives bit 7, 000 gives CARRY, and 100 gives bit 0 (rotate).
- R10: Opcode 10101 writes the bit-reversed sX, so bit i of the result is bit 7-i of the operand. The flags are unchanged.
- R11: Any other opcode with bit 15 = 1, and any shift with an unlisted fill code, produces no write and leaves the flags unchanged.
- R12: While reset is asserted, `result_o`, `wr_en_o`, `wr_addr_o`, `zero_o` and `carry_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word, held for two cycles |
| x_val_i | input | 8 | Contents of register sX |
| y_val_i | input | 8 | Contents of register sY (bits 7:5) |
| result_o | output | 8 | Write-back byte |
| wr_en_o | output | 1 | Write strobe for the register file |
| wr_addr_o | output | 3 | Destination register index |
| zero_o | output | 1 | ZERO flag |
| carry_o | output | 1 | CARRY flag |

## Verification
Arithmetic is tested with operands chosen to reach the boundaries:
- 0xFF + 0x01 wraps to zero and sets the carry.
- A subtraction that underflows sets the borrow.
- The carry-in variants are run with CARRY both set and clear, which separates them from the plain forms.

Each shift fill code is applied in both directions to patterns that differ at the two ends (0x81, 0x80, 0x01). With these patterns a wrong fill source, a wrong direction or a wrong carry-out bit each gives a different byte.

LOAD and bit-reverse run after an instruction has set both flags, so any flag disturbance shows. A stream of pseudo-random words then mixes valid, invalid and register-form encodings.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned OPC_W  = 5;
  localparam int unsigned INSN_W = 16;

  localparam logic [OPC_W-1:0] OPC_SHIFT = 5'b10100;
  localparam logic [OPC_W-1:0] OPC_REV   = 5'b10101;

  typedef enum logic [2:0] {
    FN_LOAD = 3'd0, FN_AND = 3'd1, FN_OR  = 3'd2, FN_XOR  = 3'd3,
    FN_ADD  = 3'd4, FN_ADDC = 3'd5, FN_SUB = 3'd6, FN_SUBC = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    UNIT_NONE, UNIT_ALU, UNIT_SHIFT, UNIT_REV
  } unit_e;

  typedef enum logic [2:0] {
    FILL_CARRY = 3'b000, FILL_EDGE = 3'b010, FILL_ROT = 3'b100,
    FILL_ZERO  = 3'b110, FILL_ONE  = 3'b111
  } fill_e;

  typedef struct packed {
    unit_e             unit;
    alu_fn_e           fn;
    logic              use_reg;
    logic              shift_right;
    logic [2:0]        fill;
    logic [REG_AW-1:0] dst;
    logic [DATA_W-1:0] imm;
  } ctl_t;
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output ctl_t              ctl_o
);
  logic [OPC_W-1:0] opc;
  logic             fill_ok;

  assign opc = instr_i[INSN_W-1 -: OPC_W];

  always_comb begin
    unique case (instr_i[2:0])
      FILL_CARRY, FILL_EDGE, FILL_ROT, FILL_ZERO, FILL_ONE: fill_ok = 1'b1;
      default:                                              fill_ok = 1'b0;
    endcase
  end

  always_comb begin
    ctl_o.fn          = alu_fn_e'(opc[2:0]);
    ctl_o.use_reg     = opc[3];
    ctl_o.shift_right = instr_i[3];
    ctl_o.fill        = instr_i[2:0];
    ctl_o.dst         = instr_i[DATA_W +: REG_AW];
    ctl_o.imm         = instr_i[DATA_W-1:0];
    if (!opc[OPC_W-1])                   ctl_o.unit = UNIT_ALU;
    else if (opc == OPC_SHIFT && fill_ok) ctl_o.unit = UNIT_SHIFT;
    else if (opc == OPC_REV)             ctl_o.unit = UNIT_REV;
    else                                 ctl_o.unit = UNIT_NONE;
  end
endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output logic              flag_we_o
);
  logic [DATA_W:0] sum_w, dif_w;
  logic            use_cin;

  assign use_cin = (fn_i == FN_ADDC || fn_i == FN_SUBC) ? cin_i : 1'b0;
  assign sum_w   = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, use_cin};
  // bit DATA_W of a 9-bit difference is the borrow
  assign dif_w   = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, use_cin};

  always_comb begin
    flag_we_o = (fn_i != FN_LOAD);
    cout_o    = 1'b0;
    unique case (fn_i)
      FN_LOAD:         res_o = b_i;
      FN_AND:          res_o = a_i & b_i;
      FN_OR:           res_o = a_i | b_i;
      FN_XOR:          res_o = a_i ^ b_i;
      FN_ADD, FN_ADDC: {cout_o, res_o} = sum_w;
      default:         {cout_o, res_o} = dif_w;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  logic              right_i,
  input  logic [2:0]        fill_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  logic fill_bit;
  logic near_bit; // bit on the side being filled
  logic far_bit;  // bit on the side being shifted out

  assign near_bit = right_i ? a_i[DATA_W-1] : a_i[0];
  assign far_bit  = right_i ? a_i[0] : a_i[DATA_W-1];

  always_comb begin
    unique case (fill_i)
      FILL_ONE:   fill_bit = 1'b1;
      FILL_EDGE:  fill_bit = near_bit;
      FILL_CARRY: fill_bit = cin_i;
      FILL_ROT:   fill_bit = far_bit;
      default:    fill_bit = 1'b0;
    endcase
  end

  assign cout_o = far_bit;
  assign res_o  = right_i ? {fill_bit, a_i[DATA_W-1:1]} : {a_i[DATA_W-2:0], fill_bit};
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       instr_i,
  input  logic [7:0]        x_val_i,
  input  logic [7:0]        y_val_i,
  output logic [7:0]        result_o,
  output logic              wr_en_o,
  output logic [2:0]        wr_addr_o,
  output logic              zero_o,
  output logic              carry_o
);
  ctl_t              ctl;
  logic [DATA_W-1:0] opnd_b, arith_res, shift_res, rev_res, nxt_res;
  logic              arith_c, arith_fwe, shift_c;
  logic              nxt_we, nxt_fwe, nxt_c;
  logic              phase_q, we_q, zero_q, carry_q;
  logic [DATA_W-1:0] result_q;
  logic [REG_AW-1:0] addr_q;

  alu8_decode u_dec (.instr_i(instr_i), .ctl_o(ctl));

  assign opnd_b = ctl.use_reg ? y_val_i : ctl.imm;

  alu8_arith u_arith (
    .fn_i(ctl.fn), .a_i(x_val_i), .b_i(opnd_b), .cin_i(carry_q),
    .res_o(arith_res), .cout_o(arith_c), .flag_we_o(arith_fwe)
  );

  alu8_shift u_shift (
    .right_i(ctl.shift_right), .fill_i(ctl.fill), .a_i(x_val_i),
    .cin_i(carry_q), .res_o(shift_res), .cout_o(shift_c)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign rev_res[b] = x_val_i[DATA_W-1-b];
  end

  always_comb begin
    nxt_res = rev_res;
    nxt_we  = 1'b0;
    nxt_fwe = 1'b0;
    nxt_c   = carry_q;
    unique case (ctl.unit)
      UNIT_ALU: begin
        nxt_res = arith_res; nxt_we = 1'b1; nxt_fwe = arith_fwe; nxt_c = arith_c;
      end
      UNIT_SHIFT: begin
        nxt_res = shift_res; nxt_we = 1'b1; nxt_fwe = 1'b1; nxt_c = shift_c;
      end
      UNIT_REV: nxt_we = 1'b1;
      default: ;
    endcase
  end

  // phase_q high marks the second cycle of an instruction: commit edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      we_q     <= 1'b0;
      result_q <= '0;
      addr_q   <= '0;
      zero_q   <= 1'b0;
      carry_q  <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        we_q <= nxt_we;
        if (nxt_we) begin
          result_q <= nxt_res;
          addr_q   <= ctl.dst;
        end
        if (nxt_fwe) begin
          zero_q  <= (nxt_res == '0);
          carry_q <= nxt_c;
        end
      end else begin
        we_q <= 1'b0;
      end
    end
  end

  assign result_o  = result_q;
  assign wr_en_o   = we_q;
  assign wr_addr_o = addr_q;
  assign zero_o    = zero_q;
  assign carry_o   = carry_q;
endmodule

// File: rtl/alu8_exec_chk.sv
module alu8_exec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] instr_i,
  input logic [7:0]  x_val_i,
  input logic [7:0]  result_o,
  input logic        wr_en_o,
  input logic [2:0]  wr_addr_o,
  input logic        zero_o,
  input logic        carry_o
);
  AST_WREN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R1
  AST_WR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_addr_o == $past(instr_i[10:8])); // R1
  AST_FLAGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> $stable(zero_o) && $stable(carry_o)); // R1
  AST_LOAD_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(instr_i[15]) == 1'b0 && $past(instr_i[13:11]) == 3'b000)
      |-> zero_o == $past(zero_o) && carry_o == $past(carry_o)); // R3
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(instr_i[15]) == 1'b0 && $past(instr_i[13]) == 1'b0 &&
     $past(instr_i[12:11]) != 2'b00) |-> !carry_o); // R4
  AST_ZERO_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && ($past(instr_i[15]) == 1'b0 ? $past(instr_i[13:11]) != 3'b000
                                           : $past(instr_i[15:11]) == 5'b10100))
      |-> zero_o == (result_o == 8'h00)); // R7
  AST_REV_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(instr_i[15:11]) == 5'b10101)
      |-> result_o[0] == $past(x_val_i[7]) && result_o[7] == $past(x_val_i[0])
          && zero_o == $past(zero_o)); // R10
endmodule

bind alu8_exec alu8_exec_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .x_val_i(x_val_i),
  .result_o(result_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .zero_o(zero_o), .carry_o(carry_o)
);

// File: tb/alu8_exec_test.sv
`timescale 1ns/1ps
module alu8_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  xv = '0, yv = '0;
  logic [7:0]  res;
  logic        we, zf, cf;
  logic [2:0]  wa;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic       we;
    logic [7:0] res;
    logic [2:0] addr;
    logic       z, c;
    string      tag;
  } exp_t;
  exp_t sb[$];
  event sample_ev;
  logic mz = 0, mc = 0;

  always #2 clk = ~clk;

  alu8_exec uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .x_val_i(xv), .y_val_i(yv),
    .result_o(res), .wr_en_o(we), .wr_addr_o(wa), .zero_o(zf), .carry_o(cf)
  );

  function automatic logic [15:0] mk(input logic [4:0] op, input logic [2:0] sx,
                                     input logic [7:0] lo);
    return {op, sx, lo};
  endfunction

  // reference model built from the requirement text
  task automatic model(input logic [15:0] i, input logic [7:0] x, input logic [7:0] y,
                       output exp_t e);
    logic [4:0] op; logic [7:0] b, r; logic [8:0] t; logic f, ok;
    op = i[15:11]; e.we = 0; e.res = 8'hxx; e.addr = i[10:8];
    if (!op[4]) begin
      b = op[3] ? y : i[7:0];
      e.we = 1;
      case (op[2:0])
        3'd0: r = b;
        3'd1: begin r = x & b; mc = 0; end
        3'd2: begin r = x | b; mc = 0; end
        3'd3: begin r = x ^ b; mc = 0; end
        3'd4: begin t = x + b;          r = t[7:0]; mc = t[8]; end
        3'd5: begin t = x + b + mc;     r = t[7:0]; mc = t[8]; end
        3'd6: begin t = {1'b0,x} - b;   r = t[7:0]; mc = t[8]; end
        default: begin t = {1'b0,x} - b - mc; r = t[7:0]; mc = t[8]; end
      endcase
      if (op[2:0] != 0) mz = (r == 0);
      e.res = r;
    end else if (op == 5'b10100) begin
      ok = 1;
      case (i[2:0])
        3'b110: f = 0;
        3'b111: f = 1;
        3'b010: f = i[3] ? x[7] : x[0];
        3'b000: f = mc;
        3'b100: f = i[3] ? x[0] : x[7];
        default: begin ok = 0; f = 0; end
      endcase
      if (ok) begin
        r = i[3] ? {f, x[7:1]} : {x[6:0], f};
        mc = i[3] ? x[0] : x[7];
        mz = (r == 0);
        e.we = 1; e.res = r;
      end
    end else if (op == 5'b10101) begin
      for (int k = 0; k < 8; k++) r[k] = x[7-k];
      e.we = 1; e.res = r;
    end
    e.z = mz; e.c = mc;
  endtask

  task automatic run(input logic [15:0] i, input logic [7:0] x, input logic [7:0] y,
                     input string tag);
    exp_t e;
    model(i, x, y, e);
    e.tag = tag;
    sb.push_back(e);
    instr = i; xv = x; yv = y;
    repeat (2) @(posedge clk);
    #1;
    -> sample_ev;
    @(negedge clk);
  endtask

  // monitor: pops one expectation per instruction
  always begin
    exp_t e;
    @(sample_ev);
    e = sb.pop_front();
    checks++;
    if (we !== e.we || (e.we && (res !== e.res || wa !== e.addr)) ||
        zf !== e.z || cf !== e.c) begin
      fails++;
      $display("FAIL %s instr=%h actual we=%b res=%h addr=%0d z=%b c=%b expected we=%b res=%h addr=%0d z=%b c=%b",
               e.tag, instr, we, res, wa, zf, cf, e.we, e.res, e.addr, e.z, e.c);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R12 reset state
    if (res !== 0 || we !== 0 || wa !== 0 || zf !== 0 || cf !== 0) begin
      fails++;
      $display("FAIL R12 actual res=%h we=%b addr=%0d z=%b c=%b expected all 0",
               res, we, wa, zf, cf);
    end
    rst_n = 1'b1;

    run(16'h0701, 8'h3C, 8'h00, "R3 load const s7");
    run(mk(5'b00100, 3'd2, 8'h01), 8'hFF, 8'h00, "R5 add wrap");
    run(mk(5'b00000, 3'd3, 8'h55), 8'h00, 8'h00, "R3 load keeps flags");
    run(mk(5'b01000, 3'd4, 8'h00), 8'h11, 8'h9A, "R2 load reg form");
    run(mk(5'b10101, 3'd5, 8'h00), 8'h01, 8'h00, "R10 reverse keeps flags");
    run(mk(5'b00101, 3'd1, 8'h20), 8'h10, 8'h00, "R5 addcy carry in");
    run(mk(5'b01101, 3'd1, 8'h00), 8'h10, 8'hF0, "R5 addcy no carry");
    run(mk(5'b00110, 3'd0, 8'h06), 8'h05, 8'h00, "R6 sub borrow");
    run(mk(5'b01111, 3'd6, 8'h00), 8'h05, 8'h04, "R6 subcy to zero");
    run(mk(5'b00110, 3'd0, 8'h06), 8'h05, 8'h00, "R6 sub borrow again");
    run(mk(5'b01001, 3'd2, 8'h00), 8'h0F, 8'h33, "R4 and reg");
    run(mk(5'b00010, 3'd2, 8'h30), 8'h0F, 8'h00, "R4 or const");
    run(mk(5'b00011, 3'd2, 8'h5A), 8'h5A, 8'h00, "R7 xor to zero");
    run(16'hA706, 8'h81, 8'h00, "R8 shift left fill 0");
    run(mk(5'b00110, 3'd0, 8'h01), 8'h00, 8'h00, "R6 set carry");
    run(mk(5'b10100, 3'd1, 8'h00), 8'h80, 8'h00, "R8 left fill carry");
    run(mk(5'b10100, 3'd1, 8'h08), 8'h01, 8'h00, "R9 right fill carry");
    for (int d = 0; d < 2; d++)
      foreach (sx_pat[p]) begin
        run(mk(5'b10100, 3'd6, {4'h0, d[0], 3'b110}), sx_pat[p], 8'h00, d ? "R9 fill 0" : "R8 fill 0");
        run(mk(5'b10100, 3'd6, {4'h0, d[0], 3'b111}), sx_pat[p], 8'h00, d ? "R9 fill 1" : "R8 fill 1");
        run(mk(5'b10100, 3'd6, {4'h0, d[0], 3'b010}), sx_pat[p], 8'h00, d ? "R9 fill edge" : "R8 fill edge");
        run(mk(5'b10100, 3'd6, {4'h0, d[0], 3'b000}), sx_pat[p], 8'h00, d ? "R9 fill carry" : "R8 fill carry");
        run(mk(5'b10100, 3'd6, {4'h0, d[0], 3'b100}), sx_pat[p], 8'h00, d ? "R9 rotate" : "R8 rotate");
      end
    run(mk(5'b10100, 3'd6, 8'h05), 8'h81, 8'h00, "R11 bad fill code");
    run(mk(5'b11010, 3'd1, 8'h00), 8'h00, 8'h00, "R11 flow opcode");
    run(mk(5'b10000, 3'd1, 8'h00), 8'h00, 8'h00, "R11 port opcode");
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 80; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        run(lf, lf[7:0] ^ lf[15:8], {lf[3:0], lf[15:12]}, "R7 mixed stream");
      end
    end
    finish_run();
  end

  logic [7:0] sx_pat [3] = '{8'h81, 8'h80, 8'h01};

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end
endmodule